// File: doc/BRIEF.md
# E1 Basic Frame and Signaling Multiframe Aligner

This block finds frame alignment in a serial 2.048 Mb/s E1 receive stream and, once it holds that alignment, also finds the 16-frame signaling multiframe carried in timeslot 16. One bit enters per clock. A frame is 32 timeslots of 8 bits, sent most significant bit first. Bit 1 of each timeslot is its first bit on the line. The frame-alignment word `0011011` sits in bits 2 to 8 of timeslot 0 in every second frame. The timeslot 0 of the frames between them carries a fixed 1 in bit 2.

The search runs one bit position at a time until the 7-bit word appears. The block then goes through a three-step check: the word, then bit 2 of the following frame's timeslot 0, then the word again one frame later. After that it reports basic sync on an active-low flag. While basic sync holds, a second search locks the multiframe to the first frame whose timeslot 16 starts with `0000`. A timeslot counter, a frame-in-multiframe counter and a frame-start strobe let the rest of the receiver locate each bit. The CRC-4 multiframe is handled elsewhere.

Top module: `e1FrameAligner`

## Requirements
- R1: After reset, basicSyncN and mfSyncN are 1, timeslot is 0, frameNum is 0 and frameStart is 1.
- R2: While searching, the 7-bit word `0011011` in the last seven received bits (last bit received last) sets the position to bit 8 of timeslot 0. On the next cycle, timeslot is 1 and frameStart is 0.
- R3: In the frame after a found word, a 0 in bit 2 (second bit) of timeslot 0 abandons the candidate. The search resumes with the next bit and basic sync is not declared.
- R4: basicSyncN falls at the end of timeslot 0 two frames after the found word, if bit 2 of the frame in between was 1 and the word is present again. If the word is absent, the search restarts.
- R5: In sync, the word is checked in every second frame. basicSyncN rises after three consecutive checks fail. A correct word clears the error run, so one or two errors followed by a good word keep sync.
- R6: The multiframe search runs only while basicSyncN is 0. It locks (mfSyncN 0, frameNum 0) in the first frame whose timeslot 16 bits 1 to 4 are `0000`. frameNum then counts frames modulo 16.
- R7: With multiframe lock, the timeslot 16 upper nibble is checked in frame 0. mfSyncN rises after two consecutive multiframes fail this check. A single failure followed by a good multiframe keeps lock.
- R8: On the clock edge where basic sync is lost, mfSyncN also goes to 1. mfSyncN is never 0 while basicSyncN is 1.
- R9: timeslot is the bit position within the frame divided by 8. frameStart is 1 during the first bit period of every frame.
- R10: If the word is found on the last bit period of a frame, the realignment takes precedence over the frame wrap. frameNum does not advance, frameStart stays 0 and timeslot becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxBit | input | 1 | Serial receive data, one bit per clock |
| basicSyncN | output | 1 | 0 while basic frame alignment is held |
| mfSyncN | output | 1 | 0 while signaling multiframe alignment is held |
| timeslot | output | 5 | Timeslot of the next bit to be received |
| frameNum | output | 4 | Frame number within the signaling multiframe |
| frameStart | output | 1 | 1 during the first bit period of a frame |

## Verification
Two functions can fall on the same clock edge: a successful search match, which reloads the bit position, and the natural wrap at the end of a frame, which advances the frame counter. To provoke the collision, a directed case places a 248-bit prefix that contains no alignment word ahead of the word, so that the word's last bit arrives in bit period 255. The bench then checks that timeslot reads 1, frameStart stays 0 and frameNum has not moved from 0. A second overlap is also judged: the edge where the third FAS error drops basic sync must release multiframe lock on that same edge. The bench samples both flags right after that bit.

// File: rtl/e1AlignPkg.sv
package e1AlignPkg;

  // Frame alignment word carried in bits 2..8 of timeslot 0
  localparam logic [6:0] FAS_WORD = 7'b0011011;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadAlign;  // search hit: current bit is bit 8 of timeslot 0
    logic mfAlign;    // current frame becomes multiframe frame 0
  } alignStrobe_t;

endpackage

// File: rtl/e1AlignDatapath.sv
module e1AlignDatapath
  import e1AlignPkg::*;
#(
  parameter int TS_COUNT  = 32,
  parameter int MF_FRAMES = 16,
  parameter int SIG_TS    = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         rxBit,
  input  alignStrobe_t                 strobe,
  output logic                         fasHit,
  output logic                         nfasBit2,
  output logic                         ts0End,
  output logic                         fasFrame,
  output logic                         nibTime,
  output logic                         nibZero,
  output logic                         mfFrame0,
  output logic [$clog2(TS_COUNT)-1:0]  timeslot,
  output logic [$clog2(MF_FRAMES)-1:0] frameNum,
  output logic                         frameStart
);

  localparam int FRAME_BITS = TS_COUNT * 8;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int MF_W       = $clog2(MF_FRAMES);
  localparam int TS0_END    = 7;
  localparam int NIB_END    = SIG_TS * 8 + 3;
  localparam int LAST_BIT   = FRAME_BITS - 1;

  logic [5:0]       shReg;
  logic [6:0]       win;
  logic [CNT_W-1:0] bitCnt;
  logic [MF_W-1:0]  mfCnt;
  logic             frameWrap;

  assign win       = {shReg, rxBit};
  assign fasHit    = (win == FAS_WORD);
  assign nfasBit2  = win[6];
  assign nibZero   = (win[3:0] == 4'b0000);
  assign ts0End    = (bitCnt == CNT_W'(TS0_END));
  assign nibTime   = (bitCnt == CNT_W'(NIB_END));
  assign frameWrap = (bitCnt == CNT_W'(LAST_BIT));
  assign mfFrame0  = (mfCnt == '0);

  assign timeslot   = bitCnt[CNT_W-1:3];
  assign frameNum   = mfCnt;
  assign frameStart = (bitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      bitCnt   <= '0;
      fasFrame <= 1'b0;
      mfCnt    <= '0;
    end else begin
      shReg <= win[5:0];
      if (strobe.loadAlign) begin
        bitCnt   <= CNT_W'(TS0_END + 1);
        fasFrame <= 1'b1;
      end else begin
        bitCnt <= frameWrap ? '0 : bitCnt + CNT_W'(1);
        if (frameWrap) fasFrame <= ~fasFrame;
      end
      if (strobe.mfAlign)
        mfCnt <= '0;
      else if (frameWrap && !strobe.loadAlign)
        mfCnt <= (mfCnt == MF_W'(MF_FRAMES - 1)) ? '0 : mfCnt + MF_W'(1);
    end
  end

  // R2: a search hit places the next bit in timeslot 1
  p_align_jump_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadAlign |=> (timeslot == 1 && !frameStart));

  // R10: realignment on the last bit of a frame does not advance the frame count
  p_wrap_override_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadAlign && frameWrap) |=> $stable(frameNum));

  // R6: multiframe lock marks the current frame as frame 0
  p_mf_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mfAlign |=> (frameNum == 0));

  // R9: the frame-start strobe lasts one bit period inside timeslot 0
  p_frame_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !strobe.loadAlign) |=> (!frameStart && timeslot == 0));

endmodule

// File: rtl/e1AlignControl.sv
module e1AlignControl
  import e1AlignPkg::*;
#(
  parameter int FAS_LOSS = 3,
  parameter int MF_LOSS  = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         fasHit,
  input  logic         nfasBit2,
  input  logic         ts0End,
  input  logic         fasFrame,
  input  logic         nibTime,
  input  logic         nibZero,
  input  logic         mfFrame0,
  output alignStrobe_t strobe,
  output logic         basicSyncN,
  output logic         mfSyncN
);

  localparam int FE_W = $clog2(FAS_LOSS + 1);
  localparam int ME_W = $clog2(MF_LOSS + 1);

  typedef enum logic [1:0] {HUNT, NFAS_CHK, FAS_CHK, LOCKED} alignState_t;

  alignState_t     state, nextState;
  logic [FE_W-1:0] fasErr;
  logic [ME_W-1:0] mfErr;
  logic            mfLock;
  logic            fasCheck;
  logic            lossNow;

  assign fasCheck = ts0End && fasFrame;
  assign lossNow  = (state == LOCKED) && fasCheck && !fasHit &&
                    (fasErr == FE_W'(FAS_LOSS - 1));

  assign strobe.loadAlign = (state == HUNT) && fasHit;
  assign strobe.mfAlign   = (state == LOCKED) && !lossNow && !mfLock &&
                            nibTime && nibZero;

  always_comb begin
    nextState = state;
    case (state)
      HUNT:     if (fasHit) nextState = NFAS_CHK;
      NFAS_CHK: if (ts0End) nextState = nfasBit2 ? FAS_CHK : HUNT;
      FAS_CHK:  if (ts0End) nextState = fasHit ? LOCKED : HUNT;
      LOCKED:   if (lossNow) nextState = HUNT;
      default:  nextState = HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= HUNT;
      fasErr <= '0;
      mfLock <= 1'b0;
      mfErr  <= '0;
    end else begin
      state <= nextState;
      if (state != LOCKED || lossNow)
        fasErr <= '0;
      else if (fasCheck)
        fasErr <= fasHit ? '0 : fasErr + FE_W'(1);

      if (state != LOCKED || lossNow) begin
        mfLock <= 1'b0;
        mfErr  <= '0;
      end else if (mfLock && nibTime && mfFrame0) begin
        if (nibZero)
          mfErr <= '0;
        else if (mfErr == ME_W'(MF_LOSS - 1)) begin
          mfLock <= 1'b0;
          mfErr  <= '0;
        end else
          mfErr <= mfErr + ME_W'(1);
      end else if (strobe.mfAlign) begin
        mfLock <= 1'b1;
        mfErr  <= '0;
      end
    end
  end

  assign basicSyncN = (state != LOCKED);
  assign mfSyncN    = !mfLock;

  // R8: multiframe lock only exists under basic sync
  p_mf_under_basic_r8: assert property (@(posedge clk) disable iff (!rstN)
    !mfSyncN |-> !basicSyncN);

  // R4: sync is declared only at the end of timeslot 0 holding a correct word
  p_sync_on_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(basicSyncN) |-> $past(fasHit && ts0End));

  // R5: sync is dropped only after the error run reached its limit
  p_loss_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(basicSyncN) |-> ($past(fasErr) == FE_W'(FAS_LOSS - 1)));

  // R3: a zero in NFAS bit 2 returns to the search
  p_nfas_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == NFAS_CHK && ts0End && !nfasBit2) |=> (state == HUNT));

  // R6: the multiframe search runs only under basic sync
  p_mf_hunt_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mfAlign |-> !basicSyncN);

  // R7: multiframe lock drops with basic sync held only on a bad frame-0 nibble
  p_mf_loss_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(mfSyncN) && !basicSyncN) |-> $past(nibTime && mfFrame0 && !nibZero));

endmodule

// File: rtl/e1FrameAligner.sv
module e1FrameAligner
  import e1AlignPkg::*;
#(
  parameter int TS_COUNT  = 32,
  parameter int MF_FRAMES = 16,
  parameter int SIG_TS    = 16,
  parameter int FAS_LOSS  = 3,
  parameter int MF_LOSS   = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         rxBit,
  output logic                         basicSyncN,
  output logic                         mfSyncN,
  output logic [$clog2(TS_COUNT)-1:0]  timeslot,
  output logic [$clog2(MF_FRAMES)-1:0] frameNum,
  output logic                         frameStart
);

  alignStrobe_t strobe;
  logic fasHit, nfasBit2, ts0End, fasFrame, nibTime, nibZero, mfFrame0;

  e1AlignDatapath #(
    .TS_COUNT(TS_COUNT), .MF_FRAMES(MF_FRAMES), .SIG_TS(SIG_TS)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .strobe(strobe),
    .fasHit(fasHit), .nfasBit2(nfasBit2), .ts0End(ts0End),
    .fasFrame(fasFrame), .nibTime(nibTime), .nibZero(nibZero),
    .mfFrame0(mfFrame0), .timeslot(timeslot), .frameNum(frameNum),
    .frameStart(frameStart)
  );

  e1AlignControl #(
    .FAS_LOSS(FAS_LOSS), .MF_LOSS(MF_LOSS)
  ) uControl (
    .clk(clk), .rstN(rstN), .fasHit(fasHit), .nfasBit2(nfasBit2),
    .ts0End(ts0End), .fasFrame(fasFrame), .nibTime(nibTime),
    .nibZero(nibZero), .mfFrame0(mfFrame0), .strobe(strobe),
    .basicSyncN(basicSyncN), .mfSyncN(mfSyncN)
  );

endmodule

// File: tb/tb_e1FrameAligner.sv
`timescale 1ns/1ps
module tb_e1FrameAligner;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxBit = 1'b1;
  logic       basicSyncN, mfSyncN, frameStart;
  logic [4:0] timeslot;
  logic [3:0] frameNum;

  int checks = 0;
  int errors = 0;

  // reference model state: 0 search, 1 NFAS check, 2 second word, 3 locked
  int mState, mErr, mMfErr, mfOff, mfZeroSeen;
  bit mMf;

  always #10 clk = ~clk;

  e1FrameAligner dut (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .basicSyncN(basicSyncN),
    .mfSyncN(mfSyncN), .timeslot(timeslot), .frameNum(frameNum),
    .frameStart(frameStart)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] payByte();
    return 8'($urandom) | 8'h55;   // no two adjacent zeros: no false word
  endfunction

  function automatic logic [7:0] ts0Byte(input bit isFas, input bit bad, input bit badB2);
    if (isFas) return bad ? 8'hFF : 8'h9B;
    return {1'($urandom), ~badB2, 1'b0, 5'b11111};
  endfunction

  function automatic logic [7:0] ts16Byte(input int pos, input bit bad);
    if (pos == 0) return bad ? 8'hFF : 8'h0F;
    return payByte();
  endfunction

  task automatic sendBit(input logic b);
    rxBit = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    rxBit = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic sendFrame(input int g, input bit badTs0, input bit badB2, input bit badMf);
    int pos;
    bit isFas;
    logic [7:0] by;
    string tag;
    pos = (g + mfOff) % 16;
    isFas = (g % 2 == 0);
    for (int t = 0; t < 32; t++) begin
      if (t == 0) by = ts0Byte(isFas, badTs0, badB2);
      else if (t == 16) by = ts16Byte(pos, badMf);
      else by = payByte();
      for (int b = 7; b >= 0; b--) begin
        sendBit(by[b]);
        if (t == 0 && b == 0) begin
          tag = "R4";
          case (mState)
            0: if (isFas && !badTs0) begin mState = 1; tag = "R2"; end
            1: begin mState = badB2 ? 0 : 2; tag = "R3"; end
            2: begin mState = (isFas && !badTs0) ? 3 : 0; mErr = 0; tag = "R4"; end
            default: if (isFas) begin
              tag = "R5";
              if (badTs0) begin
                mErr++;
                if (mErr == 3) begin mState = 0; mErr = 0; mMf = 0; mMfErr = 0; end
              end else mErr = 0;
            end
          endcase
          chk(basicSyncN == (mState != 3), tag, basicSyncN, mState != 3);
          chk(mfSyncN == !mMf, "R8", mfSyncN, !mMf);
          if (mState != 0) chk(timeslot == 5'd1, "R2", timeslot, 1);
        end
        if (t == 16 && b == 4) begin
          tag = "R6";
          if (mState == 3) begin
            if (!mMf) begin
              if (pos == 0 && !badMf) begin mMf = 1; mMfErr = 0; end
            end else if (pos == 0) begin
              tag = "R7";
              if (badMf) begin
                mMfErr++;
                if (mMfErr == 2) begin mMf = 0; mMfErr = 0; end
              end else mMfErr = 0;
            end
          end
          chk(mfSyncN == !mMf, tag, mfSyncN, !mMf);
          if (mMf) chk(frameNum == 4'(pos), "R6", frameNum, pos);
        end
        if (t == 31 && b == 0 && mState != 0)
          chk(frameStart == 1'b1, "R9", frameStart, 1);
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stimulus
    int len;
    bit badTs0, badMf;
    void'($urandom(32'd4711));

    // R1: reset state
    doReset();
    chk(basicSyncN == 1'b1, "R1", basicSyncN, 1);
    chk(mfSyncN == 1'b1, "R1", mfSyncN, 1);
    chk(timeslot == 5'd0, "R1", timeslot, 0);
    chk(frameNum == 4'd0, "R1", frameNum, 0);
    chk(frameStart == 1'b1, "R1", frameStart, 1);

    // R10: word completes on the last bit period of the frame
    for (int i = 0; i < 248; i++) sendBit((i % 2 == 0) ? 1'b1 : 1'b0);
    for (int b = 7; b >= 0; b--) sendBit(8'h9B >> b);
    chk(timeslot == 5'd1, "R10", timeslot, 1);
    chk(frameStart == 1'b0, "R10", frameStart, 0);
    chk(frameNum == 4'd0, "R10", frameNum, 0);
    chk(basicSyncN == 1'b1, "R10", basicSyncN, 1);

    // main run: random prefix, payload and multiframe phase
    doReset();
    mState = 0; mErr = 0; mMf = 0; mMfErr = 0; mfZeroSeen = 0;
    mfOff = int'($urandom % 16);
    len = 1 + int'($urandom % 200);
    for (int i = 0; i < len; i++) sendBit((i % 2 == 0) ? 1'b1 : 1'(($urandom)));

    for (int g = 0; g < 190; g++) begin
      badTs0 = (g == 40 || g == 46 || g == 48 || g == 52 || g == 54 ||
                g == 56 || g == 62);
      badMf = 1'b0;
      if (g >= 90 && ((g + mfOff) % 16) == 0) begin
        badMf = (mfZeroSeen == 0 || mfZeroSeen == 2 || mfZeroSeen == 3);
        mfZeroSeen++;
      end
      sendFrame(g, badTs0, (g == 59), badMf);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule